// File: doc/BRIEF.md
# Sample-Period Wall Clock and Interval Timer

This block keeps time for a multi-voice audio engine. Each sample period is split into 64 voice service slots. A one-cycle tick marks the end of each slot. The block counts the slots inside the current sample period and counts how many whole sample periods have passed since reset. Both counts are packed into one wall-clock word that software or other logic can read at any time.

The block also holds an interval timer. Software writes a 10-bit rate, in sample periods. The timer counts down one step at the end of each sample period. When it reaches terminal count, it raises a pending flag, and that flag stays set until an acknowledge pulse clears it. A newly written rate is not used at once. It is loaded only when the interval already running reaches terminal count. Enabling and merging interrupt sources is done by other logic.

Top module: `sample_clock_timer`

## Requirements
- R1: While reset is asserted and just after it is released, the wall-clock word reads 0 and the pending flag reads 0.
- R2: Wall-clock bits 5:0 hold the slot index. The index increments by one on each cycle with `slot_tick_i` high and goes from 63 to 0. When no tick arrives, the whole wall-clock word holds its value.
- R3: Wall-clock bits 25:6 hold the count of elapsed sample periods. The count increments by one, in the same cycle, when a tick arrives while the slot index is 63. At any other time it holds its value.
- R4: The sample-period count goes from its all-ones value to 0 and raises no flag.
- R5: With a loaded rate N in 1..1023, the pending flag sets after exactly N sample periods have ended. The flag sets only in a cycle where a sample period ends.
- R6: A rate of 0 means 1024 sample periods. Reset loads this rate, so the first interval after reset lasts 1024 sample periods.
- R7: A rate write does not shorten or lengthen the interval that is running. The written value is loaded at the next terminal count. If the write arrives in the same cycle as a terminal count, the value loaded at that terminal count is the old one.
- R8: Once set, the pending flag stays set until a cycle with `irq_ack_i` high. It then reads 0 from the next cycle on.
- R9: When an acknowledge and a terminal count fall in the same cycle, the pending flag stays set.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low synchronous reset |
| slot_tick_i | input | 1 | One-cycle strobe at the end of each voice service slot |
| rate_we_i | input | 1 | Write strobe for the timer rate |
| rate_wdata_i | input | 10 | New timer rate in sample periods (0 means 1024) |
| irq_ack_i | input | 1 | Clears the pending flag |
| wallclock_o | output | 26 | Sample-period count in bits 25:6, slot index in bits 5:0 |
| timer_pend_o | output | 1 | Interval-timer pending flag |

## Verification
The hardest cases to reach are the wrap of the 20-bit period count and an acknowledge that lands in the exact cycle of a terminal count.

- **Counter wrap.** With the default widths the wrap needs 2^26 ticks, far too many for a test. A second instance with a 4-bit period count runs on the same stimulus, so its wrap happens many times within a short test.
- **Acknowledge at terminal count.** The bench model predicts the cycle in which the last tick of an interval will arrive. The bench raises the acknowledge in that cycle. The bench also writes a rate in the middle of the long first interval after reset, to show that the old interval is not cut short.

// File: rtl/sct_pkg.sv
`timescale 1ns/1ps
package sct_pkg;
    // Default widths of the timing block
    localparam int DEF_SLOT_W   = 6;
    localparam int DEF_SAMPLE_W = 20;
    localparam int DEF_RATE_W   = 10;
endpackage

// File: rtl/sct_slot_seq.sv
`timescale 1ns/1ps
module sct_slot_seq #(
    parameter int SLOT_W   = sct_pkg::DEF_SLOT_W,
    parameter int SAMPLE_W = sct_pkg::DEF_SAMPLE_W
) (
    input  logic                clk,
    input  logic                rst_n,
    input  logic                slot_tick_i,
    output logic                period_end_o,
    output logic [SLOT_W-1:0]   slot_o,
    output logic [SAMPLE_W-1:0] sample_o
);
    localparam logic [SLOT_W-1:0]   LAST_SLOT  = '1;
    localparam logic [SLOT_W-1:0]   SLOT_ONE   = 1;
    localparam logic [SAMPLE_W-1:0] SAMPLE_ONE = 1;

    typedef struct packed {
        logic [SLOT_W-1:0]   slot;
        logic [SAMPLE_W-1:0] sample;
    } seq_t;

    seq_t seq_d, seq_q;

    // A sample period closes on the tick that ends the last slot
    assign period_end_o = slot_tick_i && (seq_q.slot == LAST_SLOT);

    always_comb begin
        seq_d = seq_q;
        if (slot_tick_i) begin
            seq_d.slot = seq_q.slot + SLOT_ONE;
        end
        if (period_end_o) begin
            // free-running, silent wrap
            seq_d.sample = seq_q.sample + SAMPLE_ONE;
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            seq_q <= '0;
        end else begin
            seq_q <= seq_d;
        end
    end

    assign slot_o   = seq_q.slot;
    assign sample_o = seq_q.sample;
endmodule

// File: rtl/sct_interval_timer.sv
`timescale 1ns/1ps
module sct_interval_timer #(
    parameter int RATE_W = sct_pkg::DEF_RATE_W
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              period_end_i,
    input  logic              rate_we_i,
    input  logic [RATE_W-1:0] rate_wdata_i,
    input  logic              irq_ack_i,
    output logic              pend_o
);
    localparam int              CNT_W    = RATE_W + 1;
    localparam logic [CNT_W-1:0] FULL_CNT = 1 << RATE_W;
    localparam logic [CNT_W-1:0] CNT_ONE  = 1;

    typedef struct packed {
        logic [RATE_W-1:0] rate;
        logic [CNT_W-1:0]  remain;
        logic              pend;
    } tmr_t;

    tmr_t tmr_d, tmr_q;
    logic terminal;

    // Rate 0 encodes the longest interval
    function automatic logic [CNT_W-1:0] interval_len(input logic [RATE_W-1:0] r);
        return (r == '0) ? FULL_CNT : {1'b0, r};
    endfunction

    assign terminal = period_end_i && (tmr_q.remain == CNT_ONE);

    always_comb begin
        tmr_d = tmr_q;
        if (period_end_i) begin
            // the reload reads the rate held before this cycle's write
            tmr_d.remain = terminal ? interval_len(tmr_q.rate) : tmr_q.remain - CNT_ONE;
        end
        if (rate_we_i) begin
            tmr_d.rate = rate_wdata_i;
        end
        if (terminal) begin
            tmr_d.pend = 1'b1;
        end else if (irq_ack_i) begin
            tmr_d.pend = 1'b0;
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            tmr_q.rate   <= '0;
            tmr_q.remain <= FULL_CNT;
            tmr_q.pend   <= 1'b0;
        end else begin
            tmr_q <= tmr_d;
        end
    end

    assign pend_o = tmr_q.pend;
endmodule

// File: rtl/sample_clock_timer.sv
`timescale 1ns/1ps
module sample_clock_timer #(
    parameter int SLOT_W   = sct_pkg::DEF_SLOT_W,
    parameter int SAMPLE_W = sct_pkg::DEF_SAMPLE_W,
    parameter int RATE_W   = sct_pkg::DEF_RATE_W,
    localparam int WC_W    = SLOT_W + SAMPLE_W
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              slot_tick_i,
    input  logic              rate_we_i,
    input  logic [RATE_W-1:0] rate_wdata_i,
    input  logic              irq_ack_i,
    output logic [WC_W-1:0]   wallclock_o,
    output logic              timer_pend_o
);
    logic                period_end;
    logic [SLOT_W-1:0]   slot_idx;
    logic [SAMPLE_W-1:0] sample_cnt;

    sct_slot_seq #(
        .SLOT_W  (SLOT_W),
        .SAMPLE_W(SAMPLE_W)
    ) u_seq (
        .clk         (clk),
        .rst_n       (rst_n),
        .slot_tick_i (slot_tick_i),
        .period_end_o(period_end),
        .slot_o      (slot_idx),
        .sample_o    (sample_cnt)
    );

    sct_interval_timer #(
        .RATE_W(RATE_W)
    ) u_tmr (
        .clk         (clk),
        .rst_n       (rst_n),
        .period_end_i(period_end),
        .rate_we_i   (rate_we_i),
        .rate_wdata_i(rate_wdata_i),
        .irq_ack_i   (irq_ack_i),
        .pend_o      (timer_pend_o)
    );

    assign wallclock_o = {sample_cnt, slot_idx};
endmodule

// File: rtl/sample_clock_timer_chk.sv
`timescale 1ns/1ps
module sample_clock_timer_chk #(
    parameter int SLOT_W   = sct_pkg::DEF_SLOT_W,
    parameter int SAMPLE_W = sct_pkg::DEF_SAMPLE_W,
    localparam int WC_W    = SLOT_W + SAMPLE_W
) (
    input logic            clk,
    input logic            rst_n,
    input logic            slot_tick_i,
    input logic            irq_ack_i,
    input logic [WC_W-1:0] wallclock_o,
    input logic            timer_pend_o
);
    localparam logic [SLOT_W-1:0]   LAST_SLOT  = '1;
    localparam logic [SLOT_W-1:0]   SLOT_ONE   = 1;
    localparam logic [SAMPLE_W-1:0] SAMPLE_ONE = 1;

    logic [SLOT_W-1:0]   wc_slot;
    logic [SAMPLE_W-1:0] wc_sample;
    logic                closing;

    assign wc_slot   = wallclock_o[SLOT_W-1:0];
    assign wc_sample = wallclock_o[WC_W-1:SLOT_W];
    assign closing   = slot_tick_i && (wc_slot == LAST_SLOT);

    // R2
    slot_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !slot_tick_i |=> $stable(wallclock_o));
    // R2
    slot_step_chk: assert property (@(posedge clk) disable iff (!rst_n)
        slot_tick_i |=> wc_slot == $past(wc_slot) + SLOT_ONE);
    // R3
    sample_step_chk: assert property (@(posedge clk) disable iff (!rst_n)
        closing |=> wc_sample == $past(wc_sample) + SAMPLE_ONE);
    // R3
    sample_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !closing |=> $stable(wc_sample));
    // R5
    pend_rise_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (!timer_pend_o && !closing) |=> !timer_pend_o);
    // R8
    pend_keep_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (timer_pend_o && !irq_ack_i) |=> timer_pend_o);
    // R8
    pend_ack_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (timer_pend_o && irq_ack_i && !closing) |=> !timer_pend_o);
endmodule

bind sample_clock_timer sample_clock_timer_chk #(
    .SLOT_W  (SLOT_W),
    .SAMPLE_W(SAMPLE_W)
) u_chk (
    .clk         (clk),
    .rst_n       (rst_n),
    .slot_tick_i (slot_tick_i),
    .irq_ack_i   (irq_ack_i),
    .wallclock_o (wallclock_o),
    .timer_pend_o(timer_pend_o)
);

// File: tb/sample_clock_timer_tb.sv
`timescale 1ns/1ps
module sample_clock_timer_tb;
    localparam int SMALL_W = 4;

    logic clk = 1'b0;
    always #4 clk = ~clk;

    logic       rst_n, tick, we, ack;
    logic [9:0] wdata;
    logic [25:0] wc;
    logic        pend;
    logic [9:0]  wc_small;
    logic        pend_small;

    sample_clock_timer u_dut (
        .clk(clk), .rst_n(rst_n), .slot_tick_i(tick), .rate_we_i(we),
        .rate_wdata_i(wdata), .irq_ack_i(ack), .wallclock_o(wc), .timer_pend_o(pend)
    );

    sample_clock_timer #(.SAMPLE_W(SMALL_W)) u_wrap (
        .clk(clk), .rst_n(rst_n), .slot_tick_i(tick), .rate_we_i(we),
        .rate_wdata_i(wdata), .irq_ack_i(ack), .wallclock_o(wc_small), .timer_pend_o(pend_small)
    );

    int checks = 0;
    int fails  = 0;
    bit done   = 0;

    // reference model state
    int m_slot, m_sample, m_small, m_rate, m_rem;
    bit m_pend;

    task automatic chk(input bit ok, input string tag, input longint act, input longint exp);
        checks++;
        if (!ok) begin
            fails++;
            $display("FAIL %s actual=%0h expected=%0h at %0t", tag, act, exp, $time);
        end
    endtask

    function automatic void model_reset();
        m_slot = 0; m_sample = 0; m_small = 0; m_rate = 0; m_rem = 1024; m_pend = 0;
    endfunction

    function automatic bit term_next(input bit t);
        return t && (m_slot == 63) && (m_rem == 1);
    endfunction

    function automatic void model_step(input bit t, input bit w, input int d, input bit a);
        bit pe;
        bit term;
        pe   = t && (m_slot == 63);
        term = pe && (m_rem == 1);
        if (t) m_slot = (m_slot + 1) % 64;
        if (pe) begin
            m_sample = (m_sample + 1) % (1 << 20);
            m_small  = (m_small + 1) % (1 << SMALL_W);
            m_rem    = term ? ((m_rate == 0) ? 1024 : m_rate) : m_rem - 1;
        end
        if (term) m_pend = 1;
        else if (a) m_pend = 0;
        if (w) m_rate = d;
    endfunction

    task automatic compare_all();
        chk(int'(wc[5:0]) == m_slot, "R2 slot", wc[5:0], m_slot);
        chk(int'(wc[25:6]) == m_sample, "R3 sample", wc[25:6], m_sample);
        chk(int'(wc_small[9:6]) == m_small, "R4 wrap", wc_small[9:6], m_small);
        chk(pend == m_pend, "R5 pend", pend, m_pend);
    endtask

    task automatic step(input bit t, input bit w, input int d, input bit a);
        tick = t; we = w; wdata = 10'(d); ack = a;
        @(posedge clk);
        model_step(t, w, d, a);
        #2;
        compare_all();
    endtask

    task automatic finish_run();
        if (!done) begin
            done = 1;
            $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
            $finish;
        end
    endtask

    initial begin
        #(8 * 190000);
        fails++;
        $display("FAIL watchdog expired");
        finish_run();
    end

    initial begin
        int cnt;
        void'($urandom(32'd20240517));
        rst_n = 0; tick = 0; we = 0; wdata = '0; ack = 0;
        model_reset();
        repeat (3) @(posedge clk);
        #2;
        chk(wc == '0, "R1 wallclock", wc, 0);
        chk(pend == 1'b0, "R1 pend", pend, 0);
        rst_n = 1;
        @(posedge clk);
        #2;
        chk(wc == '0 && pend == 1'b0, "R1 after release", wc, 0);

        // R6/R7: first interval is 1024 periods despite an early write of 5
        for (int i = 0; i < 65535; i++) step(1, i == 100, 5, 0);
        chk(pend == 1'b0, "R7 old interval kept", pend, 0);
        step(1, 0, 0, 0);
        chk(pend == 1'b1, "R6 1024-period interval", pend, 1);
        // R4: small counter has wrapped back to 0, main at 1024
        chk(int'(wc_small[9:6]) == 0 && int'(wc[25:6]) == 1024, "R4 silent wrap",
            {wc_small[9:6], wc[25:6]}, 1024);

        // R8: hold, then acknowledge
        for (int i = 0; i < 10; i++) step(0, 0, 0, 0);
        chk(pend == 1'b1, "R8 held", pend, 1);
        step(0, 0, 0, 1);
        chk(pend == 1'b0, "R8 cleared", pend, 0);

        // R5: next interval is exactly 5 periods
        cnt = 0;
        while (!pend && cnt < 2000) begin
            step(1, 0, 0, 0);
            cnt++;
        end
        chk(cnt == 320, "R5 interval ticks", cnt, 320);
        step(0, 0, 0, 1);

        // R9: acknowledge collides with terminal count
        cnt = 0;
        while (!term_next(1) && cnt < 2000) begin
            step(1, 0, 0, 0);
            cnt++;
        end
        step(1, 0, 0, 1);
        chk(pend == 1'b1, "R9 ack vs terminal", pend, 1);
        step(0, 0, 0, 1);
        chk(pend == 1'b0, "R9 later ack", pend, 0);

        // R7: write in the terminal cycle is not used for that reload
        cnt = 0;
        while (!term_next(1) && cnt < 2000) begin
            step(1, 0, 0, 0);
            cnt++;
        end
        step(1, 1, 2, 0);
        step(0, 0, 0, 1);
        cnt = 0;
        while (!pend && cnt < 2000) begin
            step(1, 0, 0, 0);
            cnt++;
        end
        chk(cnt == 320, "R7 same-cycle write", cnt, 320);

        // constrained random phase
        for (int i = 0; i < 20000; i++) begin
            step($urandom % 2 == 0, $urandom % 16 == 0, 1 + ($urandom % 6), $urandom % 8 == 0);
        end
        finish_run();
    end
endmodule